// File: doc/BRIEF.md
# Fault Event Timestamp Logger

This block records each confirmed fault as one record. A single-cycle strobe marks the instant a fault is confirmed, after any blanking and deglitch filtering. From that instant a saturating elapsed-cycle counter runs. The block then waits for three separate indications: the gate outputs are safe, the fault pin is valid, and PWM is inhibited. For each one it stores the delay to the first time it is seen. The three delays are kept as separate fields rather than summed into one figure.

Besides the three delays, each record holds the following fields:
- the fault reason, sampled when the fault is confirmed;
- the latch status, the clear method and the qualification result, all three sampled when the record closes;
- one overflow bit per delay, set when that indication never arrived before the record closed.

Closed records go into a four-entry circular buffer. A plain index-addressed read port returns any stored record, with index 0 always the oldest.

Top module: `flt_event_logger`

## Requirements
- R1: After reset the buffer is empty: `entryCount` is 0, `overrun` is 0 and `rdValid` is 0 for every index.
- R2: A high `faultConfirm` sampled at edge k opens a record. An indication first sampled high at edge k+n (n ≥ 1) stores delay n. Later highs of the same indication in the same record are ignored.
- R3: The three delays are independent and may complete in any order, including together. Bucket 0 is gate-safe, bucket 1 is pin-valid and bucket 2 is PWM-inhibited.
- R4: The reason is sampled at the opening edge. The codes are 0 under-voltage, 1 over-temperature, 2 short-circuit, 3 communication and 4 unknown. Input codes 5 to 7 are stored as 4.
- R5: The latch bit, the clear method and the qualified bit are sampled at the closing edge. The clear method codes are 0 enable toggle, 1 reset pin, 2 power cycle and 3 timed retry.
- R6: A record closes at the edge where its last missing indication is seen. From the next read it is readable as the newest entry.
- R7: If the elapsed count reaches 255 (2^LAT_W−1) at an edge, the record closes there. Each indication still missing stores 255 and sets its overflow bit (`rdOvf` bit i for bucket i). An indication seen at that same edge stores 255 with its overflow bit clear.
- R8: A new `faultConfirm` while a record is open closes that record at the same edge, with its missing delays saturated and flagged, and opens a new record.
- R9: The buffer holds 4 records. A write into a full buffer overwrites the oldest record, and sets `overrun`, which stays set until reset.
- R10: `rdIdx` selects records by age (0 = oldest). `rdValid` is 1 exactly when `rdIdx` < `entryCount`.
- R11: Indications that arrive while no record is open create no record and change no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultConfirm | input | 1 | Confirmed-fault strobe (reference instant) |
| gateSafe | input | 1 | Gate outputs reached the safe state |
| pinValid | input | 1 | Fault pin reached a valid level |
| pwmInhibit | input | 1 | PWM inhibited |
| reasonIn | input | 3 | Fault reason code |
| latchedIn | input | 1 | Fault latch status |
| clearIn | input | 2 | Clear method code |
| qualifiedIn | input | 1 | Ready window and re-arm result |
| rdIdx | input | 2 | Record index by age |
| rdValid | output | 1 | Selected record exists |
| rdReason | output | 3 | Stored reason |
| rdLatched | output | 1 | Stored latch bit |
| rdClear | output | 2 | Stored clear method |
| rdQualified | output | 1 | Stored qualified bit |
| rdGateLat | output | 8 | Delay to gate-safe |
| rdPinLat | output | 8 | Delay to pin-valid |
| rdInhLat | output | 8 | Delay to PWM-inhibited |
| rdOvf | output | 3 | Per-bucket overflow bits |
| entryCount | output | 3 | Stored records |
| overrun | output | 1 | Oldest record was overwritten |

## Verification
Each kind of internal fault shows up in a different way at the read port:
- **Stale seen flag.** The next record shows a saturated delay with its overflow bit set, or an earlier delay than the stimulus gave. This is readable in the cycle after that record closes.
- **Stuck open flag.** A record is never written, so `entryCount` fails to step after the expected closing edge.
- **Pointer or count error.** Records read back in the wrong age order, or `rdValid` disagrees with `entryCount`, on the first read after the write.

// File: rtl/flt_log_pkg.sv
package flt_log_pkg;

  localparam int NUM_BUCKETS = 3;

  typedef enum logic [2:0] {
    RSN_UVLO     = 3'd0,
    RSN_OVERTEMP = 3'd1,
    RSN_SHORT    = 3'd2,
    RSN_COMM     = 3'd3,
    RSN_UNKNOWN  = 3'd4
  } reason_e;

  typedef enum logic [1:0] {
    CLR_EN_TOGGLE  = 2'd0,
    CLR_RESET_PIN  = 2'd1,
    CLR_POWER_CYC  = 2'd2,
    CLR_TIMED_RTRY = 2'd3
  } clear_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                   start;
    logic                   close;
    logic [NUM_BUCKETS-1:0] hit;
    logic [NUM_BUCKETS-1:0] seen;
  } ctl_strobe_t;

endpackage

// File: rtl/flt_log_ctrl.sv
module flt_log_ctrl
  import flt_log_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   t0,
  input  logic [NUM_BUCKETS-1:0] ev,
  input  logic                   atMax,
  output ctl_strobe_t            stb
);

  logic                   openQ;
  logic [NUM_BUCKETS-1:0] seenQ;
  logic [NUM_BUCKETS-1:0] hit;
  logic                   allDone;
  logic                   closeNow;

  assign hit      = {NUM_BUCKETS{openQ}} & ev & ~seenQ;
  assign allDone  = &(seenQ | hit);
  // R6 all seen, R7 timeout, R8 preempting strobe
  assign closeNow = openQ & (allDone | atMax | t0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openQ <= 1'b0;
      seenQ <= '0;
    end else begin
      openQ <= t0 | (openQ & ~closeNow);
      seenQ <= (t0 | closeNow) ? '0 : (seenQ | hit);
    end
  end

  always_comb begin
    stb.start = t0;
    stb.close = closeNow;
    stb.hit   = hit;
    stb.seen  = seenQ;
  end

endmodule

// File: rtl/flt_log_data.sv
module flt_log_data
  import flt_log_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = PTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_strobe_t            stb,
  input  logic [2:0]             reasonIn,
  input  logic                   latchedIn,
  input  logic [1:0]             clearIn,
  input  logic                   qualifiedIn,
  input  logic [PTR_W-1:0]       rdIdx,
  output logic                   atMax,
  output logic                   rdValid,
  output logic [2:0]             rdReason,
  output logic                   rdLatched,
  output logic [1:0]             rdClear,
  output logic                   rdQualified,
  output logic [LAT_W-1:0]       rdLat [NUM_BUCKETS],
  output logic [NUM_BUCKETS-1:0] rdOvf,
  output logic [CNT_W-1:0]       entryCount,
  output logic                   overrun
);

  localparam logic [LAT_W-1:0] LAT_MAX = '1;
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);

  logic [LAT_W-1:0]       elapsed;
  logic [LAT_W-1:0]       latQ      [NUM_BUCKETS];
  logic [LAT_W-1:0]       bucketVal [NUM_BUCKETS];
  logic [NUM_BUCKETS-1:0] bucketOvf;
  reason_e                reasonQ;

  logic [LAT_W-1:0]       memLat     [DEPTH][NUM_BUCKETS];
  logic [NUM_BUCKETS-1:0] memOvf     [DEPTH];
  logic [2:0]             memReason  [DEPTH];
  logic                   memLatched [DEPTH];
  logic [1:0]             memClear   [DEPTH];
  logic                   memQual    [DEPTH];

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] oldest;
  logic [PTR_W-1:0] rdSlot;

  assign atMax = (elapsed == LAT_MAX);

  // elapsed cycles since the reference strobe, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           elapsed <= '0;
    else if (stb.start)  elapsed <= LAT_W'(1);
    else if (!atMax)     elapsed <= elapsed + LAT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          reasonQ <= RSN_UNKNOWN;
    else if (stb.start) reasonQ <= (reasonIn > 3'd4) ? RSN_UNKNOWN : reason_e'(reasonIn);
  end

  for (genvar g = 0; g < NUM_BUCKETS; g++) begin : gBucket
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           latQ[g] <= '0;
      else if (stb.hit[g]) latQ[g] <= elapsed;
    end
    assign bucketVal[g] = stb.hit[g]  ? elapsed :
                          stb.seen[g] ? latQ[g] : LAT_MAX;
    assign bucketOvf[g] = ~(stb.hit[g] | stb.seen[g]);
  end

  always_ff @(posedge clk) begin
    if (stb.close) begin
      for (int b = 0; b < NUM_BUCKETS; b++) memLat[wrPtr][b] <= bucketVal[b];
      memOvf[wrPtr]     <= bucketOvf;
      memReason[wrPtr]  <= reasonQ;
      memLatched[wrPtr] <= latchedIn;
      memClear[wrPtr]   <= clearIn;
      memQual[wrPtr]    <= qualifiedIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      entryCount <= '0;
      overrun    <= 1'b0;
    end else if (stb.close) begin
      wrPtr <= wrPtr + PTR_W'(1);
      if (entryCount == FULL_C) overrun    <= 1'b1;
      else                      entryCount <= entryCount + CNT_W'(1);
    end
  end

  assign oldest  = wrPtr - entryCount[PTR_W-1:0];
  assign rdSlot  = oldest + rdIdx;
  assign rdValid = ({1'b0, rdIdx} < entryCount);

  always_comb begin
    for (int b = 0; b < NUM_BUCKETS; b++) rdLat[b] = memLat[rdSlot][b];
    rdOvf       = memOvf[rdSlot];
    rdReason    = memReason[rdSlot];
    rdLatched   = memLatched[rdSlot];
    rdClear     = memClear[rdSlot];
    rdQualified = memQual[rdSlot];
  end

endmodule

// File: rtl/flt_event_logger.sv
module flt_event_logger
  import flt_log_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             faultConfirm,
  input  logic             gateSafe,
  input  logic             pinValid,
  input  logic             pwmInhibit,
  input  logic [2:0]       reasonIn,
  input  logic             latchedIn,
  input  logic [1:0]       clearIn,
  input  logic             qualifiedIn,
  input  logic [PTR_W-1:0] rdIdx,
  output logic             rdValid,
  output logic [2:0]       rdReason,
  output logic             rdLatched,
  output logic [1:0]       rdClear,
  output logic             rdQualified,
  output logic [LAT_W-1:0] rdGateLat,
  output logic [LAT_W-1:0] rdPinLat,
  output logic [LAT_W-1:0] rdInhLat,
  output logic [2:0]       rdOvf,
  output logic [PTR_W:0]   entryCount,
  output logic             overrun
);

  ctl_strobe_t      stb;
  logic             atMax;
  logic [LAT_W-1:0] rdLat [NUM_BUCKETS];

  flt_log_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .t0    (faultConfirm),
    .ev    ({pwmInhibit, pinValid, gateSafe}),
    .atMax (atMax),
    .stb   (stb)
  );

  flt_log_data #(.LAT_W(LAT_W), .DEPTH(DEPTH)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reasonIn    (reasonIn),
    .latchedIn   (latchedIn),
    .clearIn     (clearIn),
    .qualifiedIn (qualifiedIn),
    .rdIdx       (rdIdx),
    .atMax       (atMax),
    .rdValid     (rdValid),
    .rdReason    (rdReason),
    .rdLatched   (rdLatched),
    .rdClear     (rdClear),
    .rdQualified (rdQualified),
    .rdLat       (rdLat),
    .rdOvf       (rdOvf),
    .entryCount  (entryCount),
    .overrun     (overrun)
  );

  assign rdGateLat = rdLat[0];
  assign rdPinLat  = rdLat[1];
  assign rdInhLat  = rdLat[2];

endmodule

// File: rtl/flt_log_chk.sv
module flt_log_chk #(
  parameter int LAT_W = 8,
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdValid,
  input logic [2:0]       rdReason,
  input logic [LAT_W-1:0] rdGateLat,
  input logic [LAT_W-1:0] rdPinLat,
  input logic [LAT_W-1:0] rdInhLat,
  input logic [2:0]       rdOvf,
  input logic [PTR_W:0]   entryCount,
  input logic             overrun
);

  localparam logic [PTR_W:0] FULL_C = (PTR_W+1)'(DEPTH);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= FULL_C);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(overrun) |-> overrun);

  assert_overrun_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> (entryCount == FULL_C));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (entryCount != $past(entryCount)) |-> (entryCount == $past(entryCount) + 1'b1));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ((!rdOvf[0] || rdGateLat == '1) &&
                 (!rdOvf[1] || rdPinLat  == '1) &&
                 (!rdOvf[2] || rdInhLat  == '1)));

  assert_reason_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdReason <= 3'd4));

endmodule

bind flt_event_logger flt_log_chk #(.LAT_W(LAT_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdValid    (rdValid),
  .rdReason   (rdReason),
  .rdGateLat  (rdGateLat),
  .rdPinLat   (rdPinLat),
  .rdInhLat   (rdInhLat),
  .rdOvf      (rdOvf),
  .entryCount (entryCount),
  .overrun    (overrun)
);

// File: tb/sim_flt_event_logger.sv
`timescale 1ns/1ps
module sim_flt_event_logger;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       faultConfirm = 1'b0, gateSafe = 1'b0, pinValid = 1'b0, pwmInhibit = 1'b0;
  logic [2:0] reasonIn = '0;
  logic       latchedIn = 1'b0, qualifiedIn = 1'b0;
  logic [1:0] clearIn = '0;
  logic [1:0] rdIdx = '0;
  logic       rdValid, rdLatched, rdQualified, overrun;
  logic [2:0] rdReason, rdOvf, entryCount;
  logic [1:0] rdClear;
  logic [7:0] rdGateLat, rdPinLat, rdInhLat;

  int checkCount = 0;
  int errCount   = 0;
  bit finished   = 1'b0;

  // age-ordered model of the buffer
  int expReason[4], expLat[4], expClr[4], expQual[4], expG[4], expP[4], expI[4], expOvf[4];
  int expCount = 0;
  int expOverrun = 0;

  // reason, gate, pin, inhibit (0 = never), latched, clear, qualified
  localparam int VEC[6][7] = '{
    '{0, 3, 5, 7,   1, 0, 1},
    '{1, 9, 2, 4,   0, 1, 0},
    '{2, 1, 1, 1,   1, 2, 1},
    '{3, 0, 6, 10,  0, 3, 0},
    '{6, 2, 3, 250, 1, 3, 1},
    '{4, 255, 0, 0, 0, 1, 1}
  };

  always #2.5 clk = ~clk;

  flt_event_logger u0 (
    .clk(clk), .rstN(rstN), .faultConfirm(faultConfirm), .gateSafe(gateSafe),
    .pinValid(pinValid), .pwmInhibit(pwmInhibit), .reasonIn(reasonIn),
    .latchedIn(latchedIn), .clearIn(clearIn), .qualifiedIn(qualifiedIn),
    .rdIdx(rdIdx), .rdValid(rdValid), .rdReason(rdReason), .rdLatched(rdLatched),
    .rdClear(rdClear), .rdQualified(rdQualified), .rdGateLat(rdGateLat),
    .rdPinLat(rdPinLat), .rdInhLat(rdInhLat), .rdOvf(rdOvf),
    .entryCount(entryCount), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int latOf(input int d);
    return (d == 0) ? 255 : d;
  endfunction

  function automatic void push(input int r, input int g, input int p, input int i,
                               input int ov, input int l, input int c, input int q);
    int slot;
    if (expCount == 4) begin
      for (int k = 0; k < 3; k++) begin
        expReason[k] = expReason[k+1]; expLat[k] = expLat[k+1]; expClr[k] = expClr[k+1];
        expQual[k] = expQual[k+1]; expG[k] = expG[k+1]; expP[k] = expP[k+1];
        expI[k] = expI[k+1]; expOvf[k] = expOvf[k+1];
      end
      slot = 3;
      expOverrun = 1;
    end else begin
      slot = expCount;
      expCount++;
    end
    expReason[slot] = (r > 4) ? 4 : r;
    expG[slot] = g; expP[slot] = p; expI[slot] = i; expOvf[slot] = ov;
    expLat[slot] = l; expClr[slot] = c; expQual[slot] = q;
  endfunction

  task automatic checkAll(input string req);
    @(negedge clk);
    chk(entryCount == 3'(expCount), "R9", "entryCount", int'(entryCount), expCount);
    chk(overrun == expOverrun[0], "R9", "overrun", int'(overrun), expOverrun);
    for (int k = 0; k < 4; k++) begin
      rdIdx = 2'(k);
      #1;
      chk(rdValid == (k < expCount), "R10", "rdValid", int'(rdValid), int'(k < expCount));
      if (k < expCount) begin
        chk(rdReason == 3'(expReason[k]), "R4", "reason", int'(rdReason), expReason[k]);
        chk(rdGateLat == 8'(expG[k]), req, "gate delay", int'(rdGateLat), expG[k]);
        chk(rdPinLat == 8'(expP[k]), req, "pin delay", int'(rdPinLat), expP[k]);
        chk(rdInhLat == 8'(expI[k]), req, "inhibit delay", int'(rdInhLat), expI[k]);
        chk(rdOvf == 3'(expOvf[k]), "R7", "overflow bits", int'(rdOvf), expOvf[k]);
        chk(rdLatched == expLat[k][0], "R5", "latched", int'(rdLatched), expLat[k]);
        chk(rdClear == 2'(expClr[k]), "R5", "clear method", int'(rdClear), expClr[k]);
        chk(rdQualified == expQual[k][0], "R5", "qualified", int'(rdQualified), expQual[k]);
      end
    end
  endtask

  task automatic runRec(input int r, input int dg, input int dp, input int di,
                        input int l, input int c, input int q);
    int nEnd;
    @(negedge clk);
    faultConfirm = 1'b1; reasonIn = 3'(r);
    latchedIn = ~l[0]; clearIn = ~2'(c); qualifiedIn = ~q[0];
    @(posedge clk);
    if (dg == 0 || dp == 0 || di == 0) nEnd = 255;
    else nEnd = (dg > dp) ? ((dg > di) ? dg : di) : ((dp > di) ? dp : di);
    for (int n = 1; n <= nEnd; n++) begin
      @(negedge clk);
      faultConfirm = 1'b0; reasonIn = 3'd7;
      latchedIn = l[0]; clearIn = 2'(c); qualifiedIn = q[0];
      gateSafe = (n == dg); pinValid = (n == dp); pwmInhibit = (n == di);
      @(posedge clk);
    end
    @(negedge clk);
    gateSafe = 1'b0; pinValid = 1'b0; pwmInhibit = 1'b0;
    push(r, latOf(dg), latOf(dp), latOf(di),
         {29'd0, (di == 0), (dp == 0), (dg == 0)}, l, c, q);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(entryCount == 0, "R1", "entryCount after reset", int'(entryCount), 0);
    chk(overrun == 0, "R1", "overrun after reset", int'(overrun), 0);
    chk(rdValid == 0, "R1", "rdValid after reset", int'(rdValid), 0);
    rstN = 1'b1;

    // R11 indications with no open record
    repeat (3) begin
      @(negedge clk);
      gateSafe = 1'b1; pinValid = 1'b1; pwmInhibit = 1'b1;
    end
    @(negedge clk);
    gateSafe = 1'b0; pinValid = 1'b0; pwmInhibit = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(entryCount == 0, "R11", "entryCount after stray indications", int'(entryCount), 0);

    // table of records: R2 R3 R6 R7 R9
    for (int v = 0; v < 6; v++) begin
      runRec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      checkAll((v == 3 || v == 5) ? "R7" : "R3");
    end

    // R8 preemption by a second strobe
    @(negedge clk);
    faultConfirm = 1'b1; reasonIn = 3'd1; latchedIn = 1'b0; clearIn = 2'd0; qualifiedIn = 1'b0;
    @(posedge clk);
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      faultConfirm = (n == 4); reasonIn = (n == 4) ? 3'd3 : 3'd7;
      latchedIn = 1'b1; clearIn = 2'd2; qualifiedIn = 1'b1;
      gateSafe = (n == 2);
      @(posedge clk);
    end
    @(negedge clk);
    faultConfirm = 1'b0; reasonIn = 3'd0;
    latchedIn = 1'b0; clearIn = 2'd0; qualifiedIn = 1'b0;
    gateSafe = 1'b1; pinValid = 1'b1; pwmInhibit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    gateSafe = 1'b0; pinValid = 1'b0; pwmInhibit = 1'b0;
    push(1, 2, 255, 255, 6, 1, 2, 1);
    push(3, 1, 1, 1, 0, 0, 0, 0);
    checkAll("R8");

    // R2 only the first occurrence counts
    @(negedge clk);
    faultConfirm = 1'b1; reasonIn = 3'd2;
    @(posedge clk);
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      faultConfirm = 1'b0; reasonIn = 3'd7;
      latchedIn = 1'b0; clearIn = 2'd1; qualifiedIn = 1'b1;
      gateSafe = (n == 2 || n == 4); pinValid = (n == 3); pwmInhibit = (n == 5);
      @(posedge clk);
    end
    @(negedge clk);
    gateSafe = 1'b0; pinValid = 1'b0; pwmInhibit = 1'b0;
    push(2, 2, 3, 5, 0, 0, 1, 1);
    checkAll("R2");

    // R1 reset clears a full buffer
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(entryCount == 0, "R1", "entryCount after second reset", int'(entryCount), 0);
    chk(overrun == 0, "R1", "overrun after second reset", int'(overrun), 0);
    rdIdx = 2'd0;
    #1;
    chk(rdValid == 0, "R1", "rdValid after second reset", int'(rdValid), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checkCount, errCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      errCount++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checkCount, errCount);
      $finish;
    end
  end

endmodule